// File: doc/BRIEF.md
# Sequential Pulse Duration Verifier Chain

This block decides whether a received wake-up pattern is the right one. An upstream extractor supplies one pulse line per expected state of the pattern. While its pulse is high, each stage counts the ticks of a slow measurement enable. A stage is judged correct when it has counted exactly `MATCH_TICKS` ticks. The stages form a chain. The first stage always listens. Every later stage counts only when the stage before it holds an exact match and its own pulse is high. A wrong length anywhere stops the chain at that point.

A stage that counts too few ticks shows neither a match nor an overcount. A stage that counts too many raises its overcount flag and then ignores all further ticks, which cuts its measurement short. The interrupt fires only after the last stage holds an exact match and its pulse has already ended. Because of this, an overcount on the final state can never fire it. The interrupt is a pulse with a fixed length. When the pattern completes, every stage is cleared. The stages are also cleared after a programmable stretch of cycles in which all pulse lines stay low.

Top module: `pulse_seq_verifier`

## Requirements
- R1: After reset, `irq_o` is low and every bit of `stage_match_o` and `stage_over_o` is low.
- R2: A stage adds one to its tick count on each clock edge at which `tick_en`, its own pulse line and its enable are all high. Stage 0 is always enabled. Stage i>0 is enabled by `stage_match_o[i-1]`. An edge with `tick_en` low changes no count.
- R3: `stage_match_o[i]` is high exactly when stage i has counted `MATCH_TICKS` ticks. In that state `stage_over_o[i]` is low.
- R4: A stage that has counted fewer than `MATCH_TICKS` ticks shows both flags low. The following stage then does not count, even when its pulse carries ticks.
- R5: When a stage counts tick `MATCH_TICKS+1`, `stage_over_o[i]` goes high and `stage_match_o[i]` goes low. After that, further ticks are ignored, and the stage stays in that state until it is cleared.
- R6: `irq_o` rises at the first clock edge at which `stage_match_o[N-1]` is high and `pulse_in[N-1]` is low, provided no interrupt is active.
- R7: `irq_o` never rises while the last pulse line is high. An overcount on the last stage never produces an interrupt.
- R8: An interrupt stays high for exactly `IRQ_CYCLES` clock cycles.
- R9: On the same edge at which the pattern completes (the R6 condition), all stage counts and overcount flags clear.
- R10: A completion that occurs while an interrupt is active neither restarts nor lengthens that interrupt. It still clears the chain, so no interrupt follows from it later.
- R11: After `IDLE_CYCLES` consecutive clock edges with every pulse line low, all stages clear. At one edge fewer, the stages still hold their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Measurement tick, one system cycle wide |
| pulse_in | input | NUM_STAGES | Extracted state pulses, bit i for stage i |
| irq_o | output | 1 | Wake-up interrupt pulse |
| stage_match_o | output | NUM_STAGES | Per-stage exact-count flag |
| stage_over_o | output | NUM_STAGES | Per-stage overcount / cutoff flag |

## Verification
Two functions can fall in the same cycle: a second full pattern completing, and the countdown of an interrupt that is still running. The bench provokes this by playing a second correct pattern immediately after the first interrupt starts, finishing well inside `IRQ_CYCLES`. It judges the result in three ways. The running interrupt must keep its original length. No second interrupt may be recorded, because the scoreboard holds only one expected start. The stage flags must read all-zero in the cycle after the second completion.

// File: rtl/pvc_pkg.sv
package pvc_pkg;
  // Status of one measurement stage, as seen by its neighbour and the ports.
  typedef struct packed {
    logic match;   // exact tick count reached
    logic over;    // overcount seen, stage cut off
  } stage_stat_t;
endpackage

// File: rtl/pvc_stage.sv
module pvc_stage
  import pvc_pkg::*;
#(
  parameter int MATCH_TICKS = 2,
  parameter int CNT_W       = $clog2(MATCH_TICKS + 2)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr_i,
  input  logic        tick_en_i,
  input  logic        en_i,
  input  logic        pulse_i,
  output stage_stat_t stat_o
);
  localparam logic [CNT_W-1:0] MATCH_C = CNT_W'(MATCH_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic             cut_q;
  logic             count_step;

  // The cut flag plays the part of the disconnect: once set, the pulse no longer counts.
  assign count_step = tick_en_i & en_i & pulse_i & ~cut_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
      cut_q <= 1'b0;
    end else if (count_step) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == MATCH_C) cut_q <= 1'b1;
    end
  end

  assign stat_o.match = (cnt_q == MATCH_C);
  assign stat_o.over  = cut_q;

  // R2: without a tick, the count holds.
  assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick_en_i && !clr_i) |=> $stable(cnt_q));

  // R4: a stage that is not enabled by its predecessor does not count.
  assert_disabled_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !clr_i) |=> $stable(cnt_q));

  // R5: once cut off, the stage stays cut off and its count is frozen.
  assert_cutoff_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    (cut_q && !clr_i) |=> (cut_q && $stable(cnt_q)));
endmodule

// File: rtl/pvc_irq_gen.sv
module pvc_irq_gen #(
  parameter int IRQ_CYCLES = 8,
  parameter int LW         = $clog2(IRQ_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic done_i,
  output logic irq_o
);
  localparam logic [LW-1:0] LAST_C = LW'(IRQ_CYCLES - 1);

  logic [LW-1:0] len_q;
  logic          irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      len_q <= '0;
    end else if (irq_q) begin
      if (len_q == '0) irq_q <= 1'b0;
      else             len_q <= len_q - LW'(1);
    end else if (done_i) begin
      irq_q <= 1'b1;
      len_q <= LAST_C;
    end
  end

  assign irq_o = irq_q;

  // R8: the active pulse counts down by exactly one each cycle.
  assert_len_step_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_q && len_q != '0) |=> (irq_q && len_q == $past(len_q) - LW'(1)));

  // R10: the pulse ends on schedule even if a completion arrives meanwhile.
  assert_no_extend_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_q && len_q == '0) |=> !irq_q);
endmodule

// File: rtl/pvc_idle_timer.sv
module pvc_idle_timer #(
  parameter int IDLE_CYCLES = 64,
  parameter int IW          = $clog2(IDLE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic any_pulse_i,
  output logic expire_o
);
  localparam logic [IW-1:0] LIMIT_C = IW'(IDLE_CYCLES - 1);

  logic [IW-1:0] quiet_q;

  assign expire_o = !any_pulse_i && (quiet_q == LIMIT_C);

  always_ff @(posedge clk) begin
    if (rst || any_pulse_i || expire_o) quiet_q <= '0;
    else                                quiet_q <= quiet_q + IW'(1);
  end

  // R11: any pulse activity restarts the quiet count.
  assert_quiet_restart_R11: assert property (@(posedge clk) disable iff (rst)
    any_pulse_i |=> (quiet_q == '0));
endmodule

// File: rtl/pulse_seq_verifier.sv
module pulse_seq_verifier
  import pvc_pkg::*;
#(
  parameter int NUM_STAGES  = 3,
  parameter int MATCH_TICKS = 2,
  parameter int IRQ_CYCLES  = 8,
  parameter int IDLE_CYCLES = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_en,
  input  logic [NUM_STAGES-1:0] pulse_in,
  output logic                  irq_o,
  output logic [NUM_STAGES-1:0] stage_match_o,
  output logic [NUM_STAGES-1:0] stage_over_o
);
  localparam int CNT_W = $clog2(MATCH_TICKS + 2);
  localparam int LAST  = NUM_STAGES - 1;

  stage_stat_t           stat [NUM_STAGES];
  logic [NUM_STAGES-1:0] stage_en;
  logic                  seq_done;
  logic                  idle_expire;
  logic                  chain_clr;

  // The last match counts only once its pulse has ended, so a long final state cannot fire.
  assign seq_done  = stat[LAST].match & ~pulse_in[LAST];
  assign chain_clr = seq_done | idle_expire;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign stage_en[g] = 1'b1;
    end else begin : g_link
      assign stage_en[g] = stat[g-1].match;
    end

    pvc_stage #(
      .MATCH_TICKS (MATCH_TICKS),
      .CNT_W       (CNT_W)
    ) i_stage (
      .clk       (clk),
      .rst       (rst),
      .clr_i     (chain_clr),
      .tick_en_i (tick_en),
      .en_i      (stage_en[g]),
      .pulse_i   (pulse_in[g]),
      .stat_o    (stat[g])
    );

    assign stage_match_o[g] = stat[g].match;
    assign stage_over_o[g]  = stat[g].over;
  end

  pvc_irq_gen #(
    .IRQ_CYCLES (IRQ_CYCLES)
  ) i_irq (
    .clk    (clk),
    .rst    (rst),
    .done_i (seq_done),
    .irq_o  (irq_o)
  );

  pvc_idle_timer #(
    .IDLE_CYCLES (IDLE_CYCLES)
  ) i_idle (
    .clk         (clk),
    .rst         (rst),
    .any_pulse_i (|pulse_in),
    .expire_o    (idle_expire)
  );

  // R6: a completion with no interrupt active starts one.
  assert_fire_R6: assert property (@(posedge clk) disable iff (rst)
    (seq_done && !irq_o) |=> irq_o);

  // R7: no interrupt starts while the last pulse is still high.
  assert_hold_off_R7: assert property (@(posedge clk) disable iff (rst)
    pulse_in[LAST] |=> !$rose(irq_o));

  // R9: completion clears every stage.
  assert_clear_on_done_R9: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> (stage_match_o == '0 && stage_over_o == '0));

  // R11: an idle expiry clears every stage.
  assert_clear_on_idle_R11: assert property (@(posedge clk) disable iff (rst)
    idle_expire |=> (stage_match_o == '0 && stage_over_o == '0));
endmodule

// File: tb/test_pulse_seq_verifier.sv
module test_pulse_seq_verifier;
  localparam int N       = 3;
  localparam int M       = 2;
  localparam int IRQ_LEN = 16;
  localparam int IDLE    = 40;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_en = 1'b0;
  logic [N-1:0] pulse = '0;
  logic         irq;
  logic [N-1:0] smatch, sover;

  always #2 clk = ~clk;  // 250 MHz

  pulse_seq_verifier #(
    .NUM_STAGES (N), .MATCH_TICKS (M), .IRQ_CYCLES (IRQ_LEN), .IDLE_CYCLES (IDLE)
  ) i_pulse_seq_verifier (
    .clk (clk), .rst (rst), .tick_en (tick_en), .pulse_in (pulse),
    .irq_o (irq), .stage_match_o (smatch), .stage_over_o (sover)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  bit reported = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  // Drive one state: pulse high, n ticks each one cycle wide, pulse low.
  // Returns at the negedge where the pulse dropped; queues an expected start if asked.
  task automatic play_state(int s, int n, bit expect_irq);
    pulse[s] = 1'b1;
    for (int k = 0; k < n; k++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      @(negedge clk);
    end
    pulse[s] = 1'b0;
    if (expect_irq) exp_q.push_back(cyc + 1);
  endtask

  task automatic quiet(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Scoreboard monitor: each interrupt start must match the head of the queue.
  logic irq_prev = 1'b0;
  int   run_len  = 0;
  always @(negedge clk) begin
    int e;
    if (!rst) begin
      if (irq && !irq_prev) begin
        if (exp_q.size() == 0) begin
          check("R10", "unexpected irq start at cycle", cyc, 32'hFFFF_FFFF);
        end else begin
          e = exp_q.pop_front();
          check("R6", "irq start cycle", cyc, e);
        end
        run_len = 1;
      end else if (irq) begin
        run_len++;
      end
      if (!irq && irq_prev) check("R8", "irq length", run_len, IRQ_LEN);
    end
    irq_prev = irq;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "irq after reset", irq, 0);
    check("R1", "match after reset", smatch, 0);
    check("R1", "over after reset", sover, 0);

    // Correct pattern: each stage exactly M ticks.
    play_state(0, M, 0);
    check("R3", "stage0 match", smatch[0], 1);
    check("R3", "stage0 over", sover[0], 0);
    play_state(1, M, 0);
    check("R2", "stage1 counted when enabled", smatch[1], 1);
    play_state(2, M, 1);
    @(negedge clk);
    check("R6", "irq high after completion", irq, 1);
    check("R9", "match cleared on completion", smatch, 0);
    check("R9", "over cleared on completion", sover, 0);
    quiet(IRQ_LEN + IDLE + 4);

    // Undercount on stage 0 stops the chain.
    play_state(0, M - 1, 0);
    check("R4", "stage0 under match", smatch[0], 0);
    check("R4", "stage0 under over", sover[0], 0);
    play_state(1, M, 0);
    check("R4", "stage1 not enabled", smatch[1], 0);
    quiet(IDLE + 4);

    // Overcount on stage 0: flag, cutoff, chain stops.
    play_state(0, M + 2, 0);
    check("R5", "stage0 over set", sover[0], 1);
    check("R5", "stage0 match low", smatch[0], 0);
    play_state(1, M, 0);
    check("R5", "stage1 not enabled after over", smatch[1], 0);
    play_state(0, 3, 0);
    check("R5", "stage0 stays cut off", sover[0], 1);
    check("R5", "stage0 never back to match", smatch[0], 0);
    quiet(IDLE + 4);
    check("R11", "over cleared by idle", sover, 0);

    // Pulse without ticks leaves count alone; idle boundary.
    pulse[0] = 1'b1;
    quiet(6);
    check("R2", "no count without tick", smatch[0], 0);
    pulse[0] = 1'b0;
    play_state(0, M, 0);
    check("R2", "stage0 match after ticks", smatch[0], 1);
    quiet(IDLE - 1);
    check("R11", "still held one edge before idle", smatch[0], 1);
    quiet(1);
    check("R11", "cleared at idle limit", smatch[0], 0);
    quiet(4);

    // Overcount on the last stage never fires.
    play_state(0, M, 0);
    play_state(1, M, 0);
    play_state(2, M + 1, 0);
    check("R7", "last stage over", sover[2], 1);
    quiet(4);
    check("R7", "no irq on last overcount", irq, 0);
    quiet(IDLE + 4);

    // Last pulse held high after exact count: no irq until it ends.
    play_state(0, M, 0);
    play_state(1, M, 0);
    pulse[2] = 1'b1;
    for (int k = 0; k < M; k++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      @(negedge clk);
    end
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R7", "no irq while last pulse high", irq, 0);
    end
    pulse[2] = 1'b0;
    exp_q.push_back(cyc + 1);
    @(negedge clk);
    check("R6", "irq after last pulse ends", irq, 1);

    // Second completion during the active interrupt: discarded.
    play_state(0, M, 0);
    play_state(1, M, 0);
    play_state(2, M, 0);
    @(negedge clk);
    check("R10", "first irq still active", irq, 1);
    check("R10", "chain cleared by discarded completion", smatch, 0);
    quiet(IRQ_LEN + 8);
    check("R10", "no late irq", irq, 0);

    check("R6", "no pending expected irq", exp_q.size(), 0);
    report();
    $finish;
  end
endmodule